// File: doc/BRIEF.md
# Pulse-interval bit decoder framer

This block sits on the card side of a contactless link. The reader sends each bit as a short carrier pause. The time between one rising envelope edge and the next carries the bit value: about 100 us for a one and about 60 us for a zero. The block takes the digitized envelope level and a tick enable that runs at 1.5 ticks per microsecond. It synchronizes the level and times the interval between rising edges in ticks, then sorts each interval into a one, a zero or an invalid gap. The decoded bits are packed into a frame word.

A frame ends in one of two ways. Either the line stays quiet for longer than the widest legal one-interval, or an edge arrives whose interval fits neither window. A frame that ends with fewer than five bits is dropped without any sign at the outputs. A longer frame is announced by a single-cycle pulse. The bit count and the data word are then held until the next frame is announced. Interpreting the command in the frame is the job of downstream logic.

Top module: `pid_decoder`

## Requirements
- R1: The envelope input passes through two flops. A rising edge is seen when the previous synchronized level was 0 and the current one is 1. On each rising edge the tick counter value is taken as the interval and the counter restarts from 0.
- R2: An interval strictly between 130 and 170 ticks (131 to 169) decodes to a 1 bit.
- R3: An interval strictly between 70 and 110 ticks (71 to 109) decodes to a 0 bit.
- R4: An interval in neither window ends the frame at once if a frame is in progress. If no frame is in progress, the edge is ignored apart from restarting the counter.
- R5: While a frame is in progress, the frame ends when the counter reaches 170 ticks without a new edge.
- R6: A frame that ends with 4 bits or fewer produces no pulse, and `frame_bits` and `frame_data` keep their previous values.
- R7: The first bit of a frame goes to `frame_data` bit 0, and each later bit goes to the position given by the count so far. `frame_bits` gives the number of bits held, and every data bit at or above that count reads 0.
- R8: Once 31 bits are held, further bits are dropped while the frame stays in progress, and a count of 31 is reported.
- R9: The interval counter saturates at 3000 ticks and never wraps, so a long silence can never look like a legal interval.
- R10: `frame_valid` is high for exactly one clock per reported frame. `frame_bits` and `frame_data` change only in that cycle.
- R11: After synchronous reset `frame_valid`, `frame_bits` and `frame_data` are 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_in | input | 1 | Asynchronous envelope level, 1 = carrier on |
| tick_en | input | 1 | Interval time base, one tick per enabled cycle |
| frame_valid | output | 1 | One-cycle pulse when a frame is reported |
| frame_bits | output | 5 | Number of bits in the reported frame |
| frame_data | output | 31 | Reported bits, first bit at bit 0 |

## Verification
The checker watches the following on every cycle:
- the pulse is one cycle wide;
- the outputs hold between pulses;
- no pulse reports fewer than five bits;
- data above the count is zero;
- the assembly count never passes 31;
- the counter never passes its saturation value and restarts after each edge;
- a quiet line ends an open frame in the cycle after the limit.

Only the bench scenarios show the following:
- the decoded bit values and their order;
- the exact edges of both tolerance windows;
- that an invalid gap ends a frame at once while an idle one is ignored;
- that a short frame leaves the outputs as they were;
- that a silence longer than the counter range does not wrap into a false bit.

// File: rtl/pid_pkg.sv
package pid_pkg;

    // Decoded meaning of one rising-edge interval.
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_e;

    // Event handed from the interval timer to the framer.
    typedef struct packed {
        logic hit;   // a rising edge was seen this cycle
        sym_e sym;   // its classification
    } iv_evt_t;

    // Strict tolerance window test: centre-tol < v < centre+tol.
    function automatic logic in_window(input int unsigned v,
                                       input int unsigned centre,
                                       input int unsigned tol);
        return (v > centre - tol) && (v < centre + tol);
    endfunction

endpackage

// File: rtl/pid_sync.sv
module pid_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;
endmodule

// File: rtl/pid_interval.sv
module pid_interval
    import pid_pkg::*;
#(
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90,
    parameter int TOL_TICKS  = 20,
    parameter int STOP_TICKS = 3000,
    localparam int CNT_W     = $clog2(STOP_TICKS + 1),
    localparam int LIMIT     = ONE_TICKS + TOL_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             tick_en,
    output iv_evt_t          evt,
    output logic             quiet_limit,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] STOP_V = CNT_W'(STOP_TICKS);

    // Counter idles saturated so the first edge after reset is out of window.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= STOP_V;
        end else if (rise) begin
            cnt <= '0;
        end else if (tick_en && (cnt < STOP_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        evt.hit = rise;
        if (in_window(32'(cnt), ONE_TICKS, TOL_TICKS)) begin
            evt.sym = SYM_ONE;
        end else if (in_window(32'(cnt), ZERO_TICKS, TOL_TICKS)) begin
            evt.sym = SYM_ZERO;
        end else begin
            evt.sym = SYM_BAD;
        end
    end

    assign quiet_limit = (32'(cnt) >= LIMIT);
endmodule

// File: rtl/pid_framer.sv
module pid_framer
    import pid_pkg::*;
#(
    parameter int MAX_BITS  = 31,
    parameter int MIN_KEEP  = 5,
    localparam int BW       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  iv_evt_t             evt,
    input  logic                quiet_limit,
    output logic                active,
    output logic [BW-1:0]       asm_bits,
    output logic                frame_valid,
    output logic [BW-1:0]       frame_bits,
    output logic [MAX_BITS-1:0] frame_data
);
    localparam logic [BW-1:0] MAX_V  = BW'(MAX_BITS);
    localparam logic [BW-1:0] KEEP_V = BW'(MIN_KEEP);

    logic [MAX_BITS-1:0] asm_data;
    logic                is_bit;
    logic                bit_val;
    logic                close;

    always_comb begin
        is_bit  = evt.hit && (evt.sym != SYM_BAD);
        bit_val = (evt.sym == SYM_ONE);
        close   = active && ((evt.hit && (evt.sym == SYM_BAD)) ||
                             (!evt.hit && quiet_limit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            asm_bits    <= '0;
            asm_data    <= '0;
            frame_valid <= 1'b0;
            frame_bits  <= '0;
            frame_data  <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (is_bit) begin
                active <= 1'b1;
                if (asm_bits < MAX_V) begin
                    asm_data <= asm_data | (MAX_BITS'(bit_val) << asm_bits);
                    asm_bits <= asm_bits + 1'b1;
                end
            end else if (close) begin
                active   <= 1'b0;
                asm_bits <= '0;
                asm_data <= '0;
                if (asm_bits >= KEEP_V) begin
                    frame_valid <= 1'b1;
                    frame_bits  <= asm_bits;
                    frame_data  <= asm_data;
                end
            end
        end
    end
endmodule

// File: rtl/pid_decoder.sv
module pid_decoder
    import pid_pkg::*;
#(
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90,
    parameter int TOL_TICKS  = 20,
    parameter int STOP_TICKS = 3000,
    parameter int MAX_BITS   = 31,
    parameter int MIN_KEEP   = 5,
    localparam int CNT_W     = $clog2(STOP_TICKS + 1),
    localparam int BW        = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                env_in,
    input  logic                tick_en,
    output logic                frame_valid,
    output logic [BW-1:0]       frame_bits,
    output logic [MAX_BITS-1:0] frame_data
);
    logic             rise;
    iv_evt_t          evt;
    logic             quiet_limit;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic [BW-1:0]    asm_bits;

    pid_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (env_in),
        .rise     (rise)
    );

    pid_interval #(
        .ONE_TICKS  (ONE_TICKS),
        .ZERO_TICKS (ZERO_TICKS),
        .TOL_TICKS  (TOL_TICKS),
        .STOP_TICKS (STOP_TICKS)
    ) u_interval (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .tick_en     (tick_en),
        .evt         (evt),
        .quiet_limit (quiet_limit),
        .cnt         (cnt)
    );

    pid_framer #(
        .MAX_BITS (MAX_BITS),
        .MIN_KEEP (MIN_KEEP)
    ) u_framer (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .quiet_limit (quiet_limit),
        .active      (active),
        .asm_bits    (asm_bits),
        .frame_valid (frame_valid),
        .frame_bits  (frame_bits),
        .frame_data  (frame_data)
    );
endmodule

// File: rtl/pid_decoder_chk.sv
module pid_decoder_chk #(
    parameter int ONE_TICKS  = 150,
    parameter int TOL_TICKS  = 20,
    parameter int STOP_TICKS = 3000,
    parameter int MAX_BITS   = 31,
    parameter int MIN_KEEP   = 5,
    localparam int CNT_W     = $clog2(STOP_TICKS + 1),
    localparam int BW        = $clog2(MAX_BITS + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                rise,
    input logic [CNT_W-1:0]    cnt,
    input logic                active,
    input logic [BW-1:0]       asm_bits,
    input logic                frame_valid,
    input logic [BW-1:0]       frame_bits,
    input logic [MAX_BITS-1:0] frame_data
);
    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> (cnt == '0));

    p_quiet_end_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !rise && (32'(cnt) >= ONE_TICKS + TOL_TICKS)) |=> !active);

    p_min_len_r6: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (32'(frame_bits) >= MIN_KEEP));

    p_clean_upper_r7: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> ((frame_data >> frame_bits) == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        32'(asm_bits) <= MAX_BITS);

    p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= STOP_TICKS);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(frame_bits) && $stable(frame_data)));
endmodule

bind pid_decoder pid_decoder_chk #(
    .ONE_TICKS  (ONE_TICKS),
    .TOL_TICKS  (TOL_TICKS),
    .STOP_TICKS (STOP_TICKS),
    .MAX_BITS   (MAX_BITS),
    .MIN_KEEP   (MIN_KEEP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .cnt         (cnt),
    .active      (active),
    .asm_bits    (asm_bits),
    .frame_valid (frame_valid),
    .frame_bits  (frame_bits),
    .frame_data  (frame_data)
);

// File: tb/pid_decoder_tb.sv
`timescale 1ns/1ps
module pid_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        env_in = 1'b0;
    logic        tick_en = 1'b0;
    logic        exact = 1'b0;
    logic        frame_valid;
    logic [4:0]  frame_bits;
    logic [30:0] frame_data;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int wide   = 0;
    logic prev_fv = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pid_decoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .env_in      (env_in),
        .tick_en     (tick_en),
        .frame_valid (frame_valid),
        .frame_bits  (frame_bits),
        .frame_data  (frame_data)
    );

    // Tick every clock in exact mode, every second clock otherwise.
    always @(negedge clk) tick_en = exact ? 1'b1 : ~tick_en;

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst && frame_valid) begin
            pulses++;
            if (prev_fv) wide++;
        end
        prev_fv = frame_valid;
    end

    localparam int NV = 7;
    localparam int          V_N   [NV] = '{7, 6, 11, 5, 4, 31, 35};
    localparam logic [39:0] V_PAT [NV] = '{40'h55, 40'h19, 40'h5A3, 40'h1F,
                                           40'hA, 40'h4B3C2D1E, 40'hF7FFF0001};
    localparam logic        V_REP [NV] = '{1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b0, 1'b1, 1'b1};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Next rising edge of env_in lands exactly n clocks after the previous one.
    task automatic gap(input int n);
        repeat (n - 8) @(negedge clk);
        env_in = 1'b0;
        repeat (8) @(negedge clk);
        env_in = 1'b1;
    endtask

    task automatic send_frame(input int n, input logic [39:0] pat);
        gap(20);
        for (int i = 0; i < n; i++) gap(pat[i] ? 300 : 180);
        repeat (500) @(negedge clk);
    endtask

    // Exact mode: interval measured = clocks between edges minus one.
    task automatic run_exact(input int npre, input int last, input logic bad,
                             input logic [30:0] exp_data, input string tag);
        int p0, d1, d2;
        repeat (300) @(negedge clk);
        p0 = pulses;
        gap(20);
        for (int i = 0; i < npre; i++) gap(151);
        gap(last + 1);
        repeat (8) @(negedge clk);
        d1 = pulses - p0;
        repeat (200) @(negedge clk);
        d2 = pulses - p0;
        chk({tag, " early pulses"}, 64'(d1), bad ? 64'd1 : 64'd0);
        chk({tag, " total pulses"}, 64'(d2), 64'd1);
        chk({tag, " bits"}, 64'(frame_bits), 64'd5);
        chk({tag, " data"}, 64'(frame_data), 64'(exp_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int p0, m;
        logic [63:0] expd;
        logic [4:0]  last_bits;
        logic [30:0] last_data;

        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid after reset", 64'(frame_valid), 64'd0);
        chk("R11 bits after reset", 64'(frame_bits), 64'd0);
        chk("R11 data after reset", 64'(frame_data), 64'd0);
        repeat (20) @(negedge clk);
        chk("R11 no frame from idle", 64'(pulses), 64'd0);

        // Table walk: R1 edge timing, R2/R3 decoding, R6 drop, R7 order, R8 cap
        last_bits = '0;
        last_data = '0;
        for (int v = 0; v < NV; v++) begin
            p0 = pulses;
            send_frame(V_N[v], V_PAT[v]);
            if (V_REP[v]) begin
                m = (V_N[v] > 31) ? 31 : V_N[v];
                expd = 64'(V_PAT[v][30:0]) & ((64'd1 << m) - 64'd1);
                chk($sformatf("R1 R7 R8 vector %0d pulse", v), 64'(pulses - p0), 64'd1);
                chk($sformatf("R7 R8 vector %0d bits", v), 64'(frame_bits), 64'(m));
                chk($sformatf("R2 R3 R7 vector %0d data", v), 64'(frame_data), expd);
                last_bits = frame_bits;
                last_data = frame_data;
            end else begin
                chk($sformatf("R6 vector %0d no pulse", v), 64'(pulses - p0), 64'd0);
                chk($sformatf("R6 R10 vector %0d bits held", v), 64'(frame_bits), 64'(last_bits));
                chk($sformatf("R6 R10 vector %0d data held", v), 64'(frame_data), 64'(last_data));
            end
        end

        // R4: invalid gap ends an open frame at once, and starts the next one
        p0 = pulses;
        gap(20);
        for (int i = 0; i < 6; i++) gap(((6'h2D >> i) & 1) != 0 ? 300 : 180);
        gap(80);
        repeat (6) @(negedge clk);
        chk("R4 invalid gap closes frame", 64'(pulses - p0), 64'd1);
        chk("R4 closed frame bits", 64'(frame_bits), 64'd6);
        chk("R4 closed frame data", 64'(frame_data), 64'h2D);
        gap(294);
        for (int i = 0; i < 4; i++) gap(300);
        repeat (500) @(negedge clk);
        chk("R4 following frame pulse", 64'(pulses - p0), 64'd2);
        chk("R4 following frame bits", 64'(frame_bits), 64'd5);
        chk("R4 following frame data", 64'(frame_data), 64'h1F);

        // R9: silence beyond the counter range must not wrap into a bit
        p0 = pulses;
        gap(20);
        gap(8492);
        for (int i = 0; i < 5; i++) gap(300);
        repeat (500) @(negedge clk);
        chk("R9 long silence pulse", 64'(pulses - p0), 64'd1);
        chk("R9 long silence bits", 64'(frame_bits), 64'd5);

        // Exact windows, one tick per clock
        exact = 1'b1;
        run_exact(4, 131, 1'b0, 31'h1F, "R2 interval 131");
        run_exact(4, 169, 1'b0, 31'h1F, "R2 interval 169");
        run_exact(5, 130, 1'b1, 31'h1F, "R4 interval 130");
        run_exact(4, 109, 1'b0, 31'h0F, "R3 interval 109");
        run_exact(4, 71,  1'b0, 31'h0F, "R3 interval 71");
        run_exact(5, 110, 1'b1, 31'h1F, "R4 interval 110");
        run_exact(5, 70,  1'b1, 31'h1F, "R4 interval 70");

        // R5: quiet-line end lands near 170 ticks after the last edge
        repeat (300) @(negedge clk);
        p0 = pulses;
        gap(20);
        for (int i = 0; i < 5; i++) gap(151);
        repeat (160) @(negedge clk);
        chk("R5 no end before limit", 64'(pulses - p0), 64'd0);
        repeat (25) @(negedge clk);
        chk("R5 end at limit", 64'(pulses - p0), 64'd1);

        chk("R10 pulse width one cycle", 64'(wide), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule